// File: doc/BRIEF.md
# FIFO Fill-Level DMA Request Generator

This block sits beside a transmit FIFO and a receive FIFO of equal depth and turns their fill counts into two DMA request lines. Each FIFO has five watermark conditions: empty, not full, at least a quarter free, at least half free and at least three quarters free. Each condition has its own enable bit in a 13-bit enable word. A request line is the registered OR of the enabled conditions of its FIFO. The block also packs both fill counts into one registered status word.

The FIFO storage and the DMA engine sit outside the block. The FIFO logic supplies the fill counts every cycle. A flush strobe marks the cycle in which a FIFO is being emptied, so the request and status logic see that FIFO as empty in that cycle and do not wait for the count to catch up.

Top module: `fdrq_top`

## Requirements
- R1: While `rst_n` is low, `tx_dreq`, `rx_dreq` and `level_word` are all zero.
- R2: One cycle after sampling, `level_word` holds the effective TX count in bits 22:16 and the effective RX count in bits 6:0. All other bits of `level_word` are zero.
- R3: The empty condition holds when the effective count is 0. Its enable is `cond_en[8]` for TX and `cond_en[0]` for RX.
- R4: The not-full condition holds when the effective count is below 64. Its enable is `cond_en[10]` for TX and `cond_en[2]` for RX.
- R5: The quarter-free condition holds when free entries (64 minus the count) are at least 16, that is, when the count is at most 48. Its enable is `cond_en[11]` for TX and `cond_en[3]` for RX.
- R6: The half-free condition holds when the count is at most 32. Its enable is `cond_en[9]` for TX and `cond_en[1]` for RX.
- R7: The three-quarter-free condition holds when the count is at most 16. Its enable is `cond_en[12]` for TX and `cond_en[4]` for RX.
- R8: Each request output is a register. In the cycle after any enabled condition of its FIFO holds, the request is 1. In the cycle after no enabled condition holds, it is 0. Bits 7:5 of `cond_en` have no effect.
- R9: While `tx_flush` (or `rx_flush`) is high, that FIFO's effective count is 0, whatever count is presented. This applies to both the conditions and the status word.
- R10: A count input above 64 is clamped to 64. This applies to both the conditions and the status word.
- R11: The TX enable bits and TX inputs have no effect on `rx_dreq` or on the RX status field, and the RX bits have no effect on the TX side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 7 | Transmit FIFO fill count |
| rx_level | input | 7 | Receive FIFO fill count |
| cond_en | input | 13 | Condition enables (TX in 12:8, RX in 4:0) |
| tx_flush | input | 1 | Transmit FIFO is being emptied this cycle |
| rx_flush | input | 1 | Receive FIFO is being emptied this cycle |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| level_word | output | 32 | Packed fill counts |

## Verification
Each watermark is tried alone. The bench enables a single condition and sweeps the count through 0, 1, 15 to 17, 31 to 33, 47 to 49, 63, 64 and values above 64, so an off-by-one edge or a swapped enable bit shows up on the request line. Further patterns cover the following:
- all enables, no enables, or only the unused bits 7:5, which separate the OR from the gating;
- TX-only enables with an RX count, which exposes crosstalk between the two sides;
- flush strobes over full counts;
- a random stretch that exercises status packing together with mixed enables.

// File: rtl/fdrq_pkg.sv
package fdrq_pkg;
   localparam int COND_N  = 5;
   // Position of each watermark inside one FIFO's enable field
   localparam int CI_EMPTY = 0;
   localparam int CI_HALF  = 1;
   localparam int CI_NFULL = 2;
   localparam int CI_QTR   = 3;
   localparam int CI_3QTR  = 4;

   typedef logic [COND_N-1:0] cond_vec_t;
endpackage

// File: rtl/fdrq_level_cond.sv
module fdrq_level_cond
   import fdrq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0] count_i,
   input  logic             flush_i,
   output logic [CNT_W-1:0] eff_o,
   output cond_vec_t        cond_o
);
   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] Q1_LVL   = CNT_W'(DEPTH / 4);
   localparam logic [CNT_W-1:0] H_LVL    = CNT_W'(DEPTH / 2);
   localparam logic [CNT_W-1:0] Q3_LVL   = CNT_W'((3 * DEPTH) / 4);

   generate
      if (DEPTH < 4 || (DEPTH % 4) != 0) begin : g_bad_depth
         $error("fdrq_level_cond: DEPTH must be a multiple of 4, at least 4");
      end
   endgenerate

   always_comb begin
      if (flush_i)                eff_o = '0;
      else if (count_i > FULL_LVL) eff_o = FULL_LVL;
      else                         eff_o = count_i;
   end

   // Free-space thresholds expressed on the fill count
   always_comb begin
      cond_o           = '0;
      cond_o[CI_EMPTY] = (eff_o == '0);
      cond_o[CI_NFULL] = (eff_o <  FULL_LVL);
      cond_o[CI_QTR]   = (eff_o <= Q3_LVL);
      cond_o[CI_HALF]  = (eff_o <= H_LVL);
      cond_o[CI_3QTR]  = (eff_o <= Q1_LVL);
   end
endmodule

// File: rtl/fdrq_req_gate.sv
module fdrq_req_gate
   import fdrq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  cond_vec_t cond_i,
   input  cond_vec_t en_i,
   output logic      req_o
);
   logic any_hit;

   assign any_hit = |(cond_i & en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_o <= 1'b0;
      else        req_o <= any_hit;
   end

   AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      any_hit |=> req_o);   // R8
   AST_REQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !any_hit |=> !req_o); // R8
endmodule

// File: rtl/fdrq_status_pack.sv
module fdrq_status_pack #(
   parameter int CNT_W  = 7,
   parameter int WORD_W = 32,
   parameter int TX_LSB = 16,
   parameter int RX_LSB = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  tx_cnt_i,
   input  logic [CNT_W-1:0]  rx_cnt_i,
   output logic [WORD_W-1:0] word_o
);
   generate
      if (TX_LSB + CNT_W > WORD_W || RX_LSB + CNT_W > WORD_W) begin : g_bad_fit
         $error("fdrq_status_pack: count field exceeds word");
      end
      if (!(TX_LSB >= RX_LSB + CNT_W || RX_LSB >= TX_LSB + CNT_W)) begin : g_overlap
         $error("fdrq_status_pack: count fields overlap");
      end
   endgenerate

   logic [WORD_W-1:0] packed_w;

   always_comb begin
      packed_w = '0;
      packed_w[TX_LSB +: CNT_W] = tx_cnt_i;
      packed_w[RX_LSB +: CNT_W] = rx_cnt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_o <= '0;
      else        word_o <= packed_w;
   end
endmodule

// File: rtl/fdrq_top.sv
module fdrq_top
   import fdrq_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int EN_W        = 13,
   parameter int TX_EN_LSB   = 8,
   parameter int RX_EN_LSB   = 0,
   parameter int WORD_W      = 32,
   parameter int TX_STAT_LSB = 16,
   parameter int RX_STAT_LSB = 0,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  tx_level,
   input  logic [CNT_W-1:0]  rx_level,
   input  logic [EN_W-1:0]   cond_en,
   input  logic              tx_flush,
   input  logic              rx_flush,
   output logic              tx_dreq,
   output logic              rx_dreq,
   output logic [WORD_W-1:0] level_word
);
   localparam int N_CH = 2;   // index 0 = RX, 1 = TX
   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

   generate
      if (TX_EN_LSB + COND_N > EN_W || RX_EN_LSB + COND_N > EN_W) begin : g_bad_en
         $error("fdrq_top: enable field exceeds enable word");
      end
   endgenerate

   logic [CNT_W-1:0] lvl_a   [N_CH];
   logic             flush_a [N_CH];
   logic [CNT_W-1:0] eff_a   [N_CH];
   cond_vec_t        cond_a  [N_CH];
   logic             req_a   [N_CH];

   assign lvl_a[0]   = rx_level;
   assign lvl_a[1]   = tx_level;
   assign flush_a[0] = rx_flush;
   assign flush_a[1] = tx_flush;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      localparam int EN_LSB = (ch == 0) ? RX_EN_LSB : TX_EN_LSB;

      fdrq_level_cond #(.DEPTH(DEPTH)) u_cond (
         .count_i (lvl_a[ch]),
         .flush_i (flush_a[ch]),
         .eff_o   (eff_a[ch]),
         .cond_o  (cond_a[ch])
      );

      fdrq_req_gate u_gate (
         .clk    (clk),
         .rst_n  (rst_n),
         .cond_i (cond_a[ch]),
         .en_i   (cond_en[EN_LSB +: COND_N]),
         .req_o  (req_a[ch])
      );

      AST_EMPTY_NEST: assert property (@(posedge clk) disable iff (!rst_n)
         cond_a[ch][CI_EMPTY] |-> cond_a[ch][CI_3QTR]);  // R3
      AST_3Q_NEST: assert property (@(posedge clk) disable iff (!rst_n)
         cond_a[ch][CI_3QTR] |-> cond_a[ch][CI_HALF]);   // R7
      AST_HALF_NEST: assert property (@(posedge clk) disable iff (!rst_n)
         cond_a[ch][CI_HALF] |-> cond_a[ch][CI_QTR]);    // R6
      AST_QTR_NEST: assert property (@(posedge clk) disable iff (!rst_n)
         cond_a[ch][CI_QTR] |-> cond_a[ch][CI_NFULL]);   // R5
   end

   assign rx_dreq = req_a[0];
   assign tx_dreq = req_a[1];

   fdrq_status_pack #(
      .CNT_W  (CNT_W),
      .WORD_W (WORD_W),
      .TX_LSB (TX_STAT_LSB),
      .RX_LSB (RX_STAT_LSB)
   ) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_cnt_i (eff_a[1]),
      .rx_cnt_i (eff_a[0]),
      .word_o   (level_word)
   );

   AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> (level_word[TX_STAT_LSB +: CNT_W] == '0));   // R9
   AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> (level_word[RX_STAT_LSB +: CNT_W] == '0));   // R9
   AST_TX_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_flush && tx_level > FULL_LVL) |=>
         (level_word[TX_STAT_LSB +: CNT_W] == FULL_LVL));        // R10
   AST_RX_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_flush && rx_level > FULL_LVL) |=>
         (level_word[RX_STAT_LSB +: CNT_W] == FULL_LVL));        // R10
endmodule

// File: tb/tb_fdrq_top.sv
module tb_fdrq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  tx_level = '0;
   logic [6:0]  rx_level = '0;
   logic [12:0] cond_en = '0;
   logic        tx_flush = 1'b0;
   logic        rx_flush = 1'b0;
   logic        tx_dreq, rx_dreq;
   logic [31:0] level_word;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  have_exp = 0;
   bit  done = 0;
   bit  e_tx, e_rx;
   logic [31:0] e_word;
   string cur_tag = "R1";

   always #5 clk = ~clk;

   fdrq_top dut (
      .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
      .cond_en(cond_en), .tx_flush(tx_flush), .rx_flush(rx_flush),
      .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .level_word(level_word)
   );

   // Reference: effective count after flush and clamp (R9, R10)
   function automatic int eff(int c, bit fl);
      if (fl) return 0;
      if (c > 64) return 64;
      return c;
   endfunction

   // Reference: field bit0 empty (R3), bit1 half (R6), bit2 not full (R4),
   // bit3 quarter (R5), bit4 three-quarter (R7)
   function automatic bit req_of(int c, int en5);
      bit hit = 0;
      int fr = 64 - c;
      if ((en5 & 1)  && c == 0)  hit = 1;
      if ((en5 & 2)  && fr >= 32) hit = 1;
      if ((en5 & 4)  && c < 64)  hit = 1;
      if ((en5 & 8)  && fr >= 16) hit = 1;
      if ((en5 & 16) && fr >= 48) hit = 1;
      return hit;
   endfunction

   task automatic compare();
      n_vec++;
      if (tx_dreq !== e_tx) begin
         n_bad++;
         $display("FAIL %s tx_dreq got %0d exp %0d", cur_tag, tx_dreq, e_tx);
      end
      if (rx_dreq !== e_rx) begin
         n_bad++;
         $display("FAIL %s rx_dreq got %0d exp %0d", cur_tag, rx_dreq, e_rx);
      end
      if (level_word !== e_word) begin
         n_bad++;
         $display("FAIL %s level_word got %h exp %h", cur_tag, level_word, e_word);
      end
   endtask

   task automatic step(int tl, int rl, int en, bit tf, bit rf);
      int te, re;
      @(negedge clk);
      if (have_exp) compare();
      tx_level = 7'(tl); rx_level = 7'(rl); cond_en = 13'(en);
      tx_flush = tf; rx_flush = rf;
      te = eff(tl, tf); re = eff(rl, rf);
      e_tx   = req_of(te, (en >> 8) & 31);
      e_rx   = req_of(re, en & 31);
      e_word = 32'(te) << 16 | 32'(re);
      have_exp = 1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int pts[16] = '{0, 1, 15, 16, 17, 31, 32, 33, 47, 48, 49, 63, 64, 65, 100, 127};
      string ctag[5] = '{"R3", "R6", "R4", "R5", "R7"};
      // R1: reset state
      tx_level = 7'd5; rx_level = 7'd5; cond_en = 13'h1F1F;
      e_tx = 0; e_rx = 0; e_word = '0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         compare();
      end
      rst_n = 1'b1;

      // R3..R7: each watermark alone on both sides, boundary sweep
      for (int k = 0; k < 5; k++) begin
         cur_tag = ctag[k];
         foreach (pts[i]) step(pts[i], pts[15 - i], (1 << k) | (1 << (k + 8)), 0, 0);
         foreach (pts[i]) step(pts[i], pts[i], (1 << (k + 8)), 0, 0);
      end

      // R8: OR of all, none, ignored bits, toggling
      cur_tag = "R8";
      foreach (pts[i]) step(pts[i], pts[i], 13'h1F1F, 0, 0);
      foreach (pts[i]) step(pts[i], pts[i], 13'h0000, 0, 0);
      foreach (pts[i]) step(pts[i], pts[i], 13'h00E0, 0, 0);
      for (int i = 0; i < 10; i++) step(i[0] ? 0 : 64, i[0] ? 64 : 0, 13'h0101, 0, 0);

      // R11: one side enabled, other side must stay quiet
      cur_tag = "R11";
      foreach (pts[i]) step(0, pts[i], 13'h1F00, 0, 0);
      foreach (pts[i]) step(pts[i], 0, 13'h001F, 0, 0);

      // R9: flush overrides full counts
      cur_tag = "R9";
      for (int i = 0; i < 8; i++) step(64, 127, 13'h0101, i[0], i[1]);
      step(64, 64, 13'h0101, 1, 1);
      step(64, 64, 13'h0101, 0, 0);

      // R10: over-range counts clamp to full
      cur_tag = "R10";
      for (int c = 64; c < 128; c += 7) step(c, 127 - (c - 64), 13'h1F1F, 0, 0);

      // R2: random mixed traffic, status packing
      cur_tag = "R2";
      for (int i = 0; i < 400; i++)
         step($urandom_range(0, 127), $urandom_range(0, 127),
              $urandom_range(0, 8191), ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 7) == 0));
      @(negedge clk);
      compare();
      finish_run();
   end
endmodule